// File: doc/BRIEF.md
# Disc Video Scan and Frame Timing Recovery

This block takes a stream of level codes from a mechanically scanned, low-definition video signal. The signal has already been sampled once per pixel period and compared against thresholds. From that stream the block rebuilds the picture timing. A picture holds 32 scans of 80 pixel periods each. A normal scan carries 74 video pixels and then ends in a 6-period sync run. The final scan of every picture is held at sync level for its whole length.

Two recovery steps run on the stream. A short run of sync samples realigns the pixel position. A very long run realigns the scan position to the top of the picture. A lock tracker watches whether each picture-length sync run arrives on the scan where the counters expect it. Downstream logic gets the recovered scan and pixel indices, the video pixel as one bit, and a strobe that marks which samples are real picture content. That content can then be redrawn or stored.

Samples are accepted only on cycles where the sample-enable strobe is high. The block keeps no clock relation to the original scanning.

Top module: `tvs_sync_recover`

## Requirements
- R1: The level code is 2 bits. 2'b00 is sync, 2'b01 is black and 2'b10 is white. 2'b11 is treated as black. `pixel_bit` is 1 only for a white sample, and a 2'b11 sample never counts toward a sync run.
- R2: A cycle with `sample_en` low changes none of `pixel_idx`, `scan_idx`, `locked` or `pixel_bit`, and `video_valid` is low in the following cycle.
- R3: All outputs are registered and describe the sample accepted on the previous clock edge. `video_valid` is high for that single cycle only.
- R4: Each accepted sample advances `pixel_idx` by one. After 79 it wraps to 0 and `scan_idx` advances, and `scan_idx` wraps from 31 to 0.
- R5: The first non-sync sample after a run of at least 4 sync samples gets `pixel_idx` 0 and `scan_idx` one above the previous scan.
- R6: A run of 1 to 3 sync samples leaves the pixel and scan counting unchanged.
- R7: The first non-sync sample after a run of at least 60 sync samples gets `pixel_idx` 0 and `scan_idx` 0.
- R8: `locked` goes high on the first sample of a picture when the two most recent picture-length sync runs each ended while `scan_idx` was 31.
- R9: `locked` drops, and the count of good pictures restarts, in two cases. The first is a picture-length sync run that ends with `scan_idx` other than 31. The second is `scan_idx` leaving 31 without such a run.
- R10: `video_valid` is high only for samples with `pixel_idx` 0 to 73 and `scan_idx` 0 to 30 while `locked` is high.
- R11: After reset, `locked`, `video_valid` and `pixel_bit` are 0, `pixel_idx` is 79 and `scan_idx` is 31, so the first sample lands on pixel 0 of scan 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Accept `level` on this cycle |
| level | input | 2 | Sampled level code |
| locked | output | 1 | Picture timing is locked |
| video_valid | output | 1 | Accepted sample is picture content |
| pixel_bit | output | 1 | 1 when the accepted sample was white |
| pixel_idx | output | 7 | Recovered pixel position within the scan |
| scan_idx | output | 5 | Recovered scan position within the picture |

## Verification
The counters or the run length can go wrong. A wrong pixel or scan counter shows up on `pixel_idx` and `scan_idx` one cycle after the sample that caused it. A wrong run length shows at the first non-sync sample after a sync run, because that sample either snaps to pixel 0 or fails to. An error in the lock tracker only shows at a picture boundary, up to a full picture of 2560 samples later, as `locked` changing on the first sample of the next picture. Every sample is compared against indices, bit, valid and lock computed from its position in the stimulus. The stimulus includes a run of three sync samples, a split run with a reserved code in the middle, a picture that ends early, and a picture with no all-sync scan.

// File: rtl/tvs_pkg.sv
package tvs_pkg;

    typedef enum logic [1:0] {
        LVL_SYNC  = 2'b00,
        LVL_BLACK = 2'b01,
        LVL_WHITE = 2'b10,
        LVL_RSVD  = 2'b11
    } level_e;

    typedef struct packed {
        logic is_sync;
        logic is_white;
    } lvl_class_t;

    function automatic lvl_class_t classify(input logic [1:0] code);
        lvl_class_t c;
        c.is_sync  = (code == LVL_SYNC);
        c.is_white = (code == LVL_WHITE);
        return c;
    endfunction

    typedef struct packed {
        logic line_evt;
        logic frame_evt;
    } sync_evt_t;

endpackage

// File: rtl/tvs_run_detect.sv
module tvs_run_detect #(
    parameter int LINE_MIN  = 4,
    parameter int FRAME_MIN = 60
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                is_sync,
    output tvs_pkg::sync_evt_t  evt
);
    localparam int RUN_W = $clog2(FRAME_MIN + 1);
    localparam logic [RUN_W-1:0] RUN_LINE  = RUN_W'(LINE_MIN);
    localparam logic [RUN_W-1:0] RUN_FRAME = RUN_W'(FRAME_MIN);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (en) begin
            if (!is_sync)
                run_q <= '0;
            else if (run_q != RUN_FRAME)
                run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        evt.frame_evt = en && !is_sync && (run_q >= RUN_FRAME);
        evt.line_evt  = en && !is_sync && (run_q >= RUN_LINE) && (run_q < RUN_FRAME);
    end
endmodule

// File: rtl/tvs_timebase.sv
module tvs_timebase #(
    parameter int PIX_PER_SCAN = 80,
    parameter int SCANS        = 32,
    localparam int PIX_W  = $clog2(PIX_PER_SCAN),
    localparam int SCAN_W = $clog2(SCANS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  tvs_pkg::sync_evt_t  evt,
    output logic [PIX_W-1:0]    pix,
    output logic [SCAN_W-1:0]   scan,
    output logic [PIX_W-1:0]    pix_nxt,
    output logic [SCAN_W-1:0]   scan_nxt,
    output logic                at_last_scan,
    output logic                skip_evt
);
    localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(PIX_PER_SCAN - 1);
    localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SCANS - 1);

    logic [PIX_W-1:0]  pix_q;
    logic [SCAN_W-1:0] scan_q;
    logic              new_scan;

    function automatic logic [SCAN_W-1:0] scan_inc(input logic [SCAN_W-1:0] s);
        return (s == SCAN_LAST) ? '0 : s + 1'b1;
    endfunction

    always_comb begin
        new_scan = evt.line_evt || (pix_q == PIX_LAST);
        pix_nxt  = pix_q;
        scan_nxt = scan_q;
        if (en) begin
            if (evt.frame_evt) begin
                pix_nxt  = '0;
                scan_nxt = '0;
            end else if (new_scan) begin
                pix_nxt  = '0;
                scan_nxt = scan_inc(scan_q);
            end else begin
                pix_nxt  = pix_q + 1'b1;
            end
        end
        at_last_scan = (scan_q == SCAN_LAST);
        skip_evt     = en && !evt.frame_evt && new_scan && at_last_scan;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= PIX_LAST;
            scan_q <= SCAN_LAST;
        end else begin
            pix_q  <= pix_nxt;
            scan_q <= scan_nxt;
        end
    end

    assign pix  = pix_q;
    assign scan = scan_q;
endmodule

// File: rtl/tvs_lock.sv
module tvs_lock #(
    parameter int LOCK_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_evt,
    input  logic at_last_scan,
    input  logic skip_evt,
    output logic locked_nxt,
    output logic locked
);
    localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
    localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_FRAMES);

    logic [GOOD_W-1:0] good_q, good_nxt;

    always_comb begin
        good_nxt = good_q;
        if (frame_evt) begin
            if (!at_last_scan)
                good_nxt = '0;
            else if (good_q != GOOD_MAX)
                good_nxt = good_q + 1'b1;
        end else if (skip_evt) begin
            good_nxt = '0;
        end
        locked_nxt = (good_nxt == GOOD_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            good_q <= '0;
            locked <= 1'b0;
        end else begin
            good_q <= good_nxt;
            locked <= locked_nxt;
        end
    end
endmodule

// File: rtl/tvs_sync_recover.sv
module tvs_sync_recover #(
    parameter int PIX_PER_SCAN = 80,
    parameter int ACTIVE_PIX   = 74,
    parameter int SCANS        = 32,
    parameter int LINE_MIN     = 4,
    parameter int FRAME_MIN    = 60,
    parameter int LOCK_FRAMES  = 2,
    localparam int PIX_W  = $clog2(PIX_PER_SCAN),
    localparam int SCAN_W = $clog2(SCANS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic [1:0]        level,
    output logic              locked,
    output logic              video_valid,
    output logic              pixel_bit,
    output logic [PIX_W-1:0]  pixel_idx,
    output logic [SCAN_W-1:0] scan_idx
);
    import tvs_pkg::*;

    localparam logic [PIX_W-1:0]  PIX_ACT   = PIX_W'(ACTIVE_PIX);
    localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SCANS - 1);

    lvl_class_t        cls;
    sync_evt_t         evt;
    logic [PIX_W-1:0]  pix_nxt;
    logic [SCAN_W-1:0] scan_nxt;
    logic              at_last_scan, skip_evt, locked_nxt;

    assign cls = classify(level);

    tvs_run_detect #(
        .LINE_MIN (LINE_MIN),
        .FRAME_MIN(FRAME_MIN)
    ) u_run (
        .clk    (clk),
        .rst    (rst),
        .en     (sample_en),
        .is_sync(cls.is_sync),
        .evt    (evt)
    );

    tvs_timebase #(
        .PIX_PER_SCAN(PIX_PER_SCAN),
        .SCANS       (SCANS)
    ) u_tb (
        .clk         (clk),
        .rst         (rst),
        .en          (sample_en),
        .evt         (evt),
        .pix         (pixel_idx),
        .scan        (scan_idx),
        .pix_nxt     (pix_nxt),
        .scan_nxt    (scan_nxt),
        .at_last_scan(at_last_scan),
        .skip_evt    (skip_evt)
    );

    tvs_lock #(
        .LOCK_FRAMES(LOCK_FRAMES)
    ) u_lock (
        .clk         (clk),
        .rst         (rst),
        .frame_evt   (evt.frame_evt),
        .at_last_scan(at_last_scan),
        .skip_evt    (skip_evt),
        .locked_nxt  (locked_nxt),
        .locked      (locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            video_valid <= 1'b0;
            pixel_bit   <= 1'b0;
        end else begin
            video_valid <= sample_en && locked_nxt && (pix_nxt < PIX_ACT) && (scan_nxt < SCAN_LAST);
            if (sample_en)
                pixel_bit <= cls.is_white;
        end
    end
endmodule

// File: rtl/tvs_sync_chk.sv
module tvs_sync_chk #(
    parameter int PIX_PER_SCAN = 80,
    parameter int ACTIVE_PIX   = 74,
    parameter int SCANS        = 32,
    localparam int PIX_W  = $clog2(PIX_PER_SCAN),
    localparam int SCAN_W = $clog2(SCANS)
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_en,
    input logic [1:0]        level,
    input logic              locked,
    input logic              video_valid,
    input logic              pixel_bit,
    input logic [PIX_W-1:0]  pixel_idx,
    input logic [SCAN_W-1:0] scan_idx
);
    localparam logic [PIX_W-1:0]  C_PIX_ACT = PIX_W'(ACTIVE_PIX);
    localparam logic [PIX_W-1:0]  C_PIX_LST = PIX_W'(PIX_PER_SCAN - 1);
    localparam logic [SCAN_W-1:0] C_SCN_LST = SCAN_W'(SCANS - 1);

    // R10
    valid_window_chk: assert property (@(posedge clk) disable iff (rst)
        video_valid |-> (locked && pixel_idx < C_PIX_ACT && scan_idx < C_SCN_LST));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(pixel_idx) && $stable(scan_idx) && $stable(locked)
                        && $stable(pixel_bit) && !video_valid));

    // R8
    lock_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (pixel_idx == '0 && scan_idx == '0));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        pixel_idx <= C_PIX_LST);

    // R1
    white_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && level == 2'b10) |=> pixel_bit);

    // R1
    rsvd_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && level == 2'b11) |=> !pixel_bit);
endmodule

bind tvs_sync_recover tvs_sync_chk #(
    .PIX_PER_SCAN(PIX_PER_SCAN),
    .ACTIVE_PIX  (ACTIVE_PIX),
    .SCANS       (SCANS)
) i_tvs_sync_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_en  (sample_en),
    .level      (level),
    .locked     (locked),
    .video_valid(video_valid),
    .pixel_bit  (pixel_bit),
    .pixel_idx  (pixel_idx),
    .scan_idx   (scan_idx)
);

// File: tb/test_tvs_sync_recover.sv
`timescale 1ns/1ps
module test_tvs_sync_recover;

    typedef struct {
        logic        valid;
        logic        bitv;
        logic        lock;
        int          pix;
        int          scan;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_en = 1'b0;
    logic [1:0] level = 2'b01;
    logic       locked, video_valid, pixel_bit;
    logic [6:0] pixel_idx;
    logic [4:0] scan_idx;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    logic captured = 1'b0;
    int   last_pix = 79, last_scan = 31;
    logic last_lock = 1'b0, last_bit = 1'b0;
    logic mon_on = 1'b0;

    always #5 clk = ~clk;

    tvs_sync_recover i_tvs_sync_recover (
        .clk(clk), .rst(rst), .sample_en(sample_en), .level(level),
        .locked(locked), .video_valid(video_valid), .pixel_bit(pixel_bit),
        .pixel_idx(pixel_idx), .scan_idx(scan_idx)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // driver: one sample, expectation pushed to the scoreboard
    task automatic send(input logic [1:0] code, input int pix, input int scan,
                        input logic lock, input string tag);
        exp_t e;
        e.pix   = pix;
        e.scan  = scan;
        e.lock  = lock;
        e.bitv  = (code == 2'b10);
        e.valid = lock && pix < 74 && scan < 31;
        e.tag   = tag;
        @(posedge clk); #1;
        sample_en = 1'b1;
        level     = code;
        q.push_back(e);
        @(posedge clk); #1;
        sample_en = 1'b0;
        level     = 2'b00;
        if (pix % 4 == 3) repeat (2) @(posedge clk);
    endtask

    // one picture: scans first..last, the last one all-sync when has_fs
    task automatic send_frame(input int first, input int last, input bit has_fs,
                              input logic lock, input bit glitch);
        for (int s = first; s <= last; s++) begin
            for (int p = 0; p < 80; p++) begin
                logic [1:0] code;
                string tag;
                code = 2'((p * 3 + s) % 3 + 1);
                tag  = (p == 0) ? ((s == 0) ? "R5 R7" : "R5") : "R4";
                if ((has_fs && s == last) || p >= 74) code = 2'b00;
                if (glitch && s == 5 && p >= 20 && p <= 22) begin
                    code = 2'b00; tag = "R6";
                end
                if (glitch && s == 7 && p >= 20 && p <= 24) begin
                    code = (p == 22) ? 2'b11 : 2'b00; tag = "R1 R6";
                end
                if (glitch && (s == 5 || s == 7) && p > 22 && p < 30) tag = "R6";
                send(code, p, s, lock, tag);
            end
        end
    endtask

    // monitor
    always @(posedge clk) captured <= sample_en;

    always @(negedge clk) begin
        if (mon_on) begin
            if (captured) begin
                exp_t e;
                if (q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected sample", 0, 1);
                end else begin
                    e = q.pop_front();
                    chk(int'(pixel_idx) == e.pix, e.tag, "pixel_idx", int'(pixel_idx), e.pix);
                    chk(int'(scan_idx) == e.scan, e.tag, "scan_idx", int'(scan_idx), e.scan);
                    chk(pixel_bit == e.bitv, "R1", "pixel_bit", int'(pixel_bit), int'(e.bitv));
                    chk(locked == e.lock, "R8 R9", "locked", int'(locked), int'(e.lock));
                    chk(video_valid == e.valid, "R10 R3", "video_valid", int'(video_valid), int'(e.valid));
                end
                last_pix = int'(pixel_idx); last_scan = int'(scan_idx);
                last_lock = locked; last_bit = pixel_bit;
            end else begin
                chk(video_valid == 1'b0, "R2 R3", "idle video_valid", int'(video_valid), 0);
                chk(int'(pixel_idx) == last_pix && int'(scan_idx) == last_scan
                    && locked == last_lock && pixel_bit == last_bit,
                    "R2", "idle hold pixel_idx", int'(pixel_idx), last_pix);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", "cycles", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(locked == 1'b0, "R11", "locked", int'(locked), 0);
        chk(video_valid == 1'b0, "R11", "video_valid", int'(video_valid), 0);
        chk(pixel_bit == 1'b0, "R11", "pixel_bit", int'(pixel_bit), 0);
        chk(int'(pixel_idx) == 79, "R11", "pixel_idx", int'(pixel_idx), 79);
        chk(int'(scan_idx) == 31, "R11", "scan_idx", int'(scan_idx), 31);
        mon_on = 1'b1;

        // partial scan: 30 black, then a 6-sample sync run, picture continues at scan 1
        for (int p = 0; p < 30; p++) send(2'b01, p, 0, 1'b0, "R11 R4");
        for (int p = 30; p < 36; p++) send(2'b00, p, 0, 1'b0, "R4");
        send_frame(1, 31, 1'b1, 1'b0, 1'b0);   // first good picture
        send_frame(0, 31, 1'b1, 1'b0, 1'b0);   // second good picture
        send_frame(0, 31, 1'b1, 1'b1, 1'b0);   // R8 locked from its first sample
        send_frame(0, 31, 1'b1, 1'b1, 1'b1);   // R6 short runs, R1 reserved code
        send_frame(0, 20, 1'b1, 1'b1, 1'b0);   // early picture-length run
        send_frame(0, 31, 1'b1, 1'b0, 1'b0);   // R9 dropped
        send_frame(0, 31, 1'b1, 1'b0, 1'b0);
        send_frame(0, 31, 1'b1, 1'b1, 1'b0);   // relocked
        send_frame(0, 31, 1'b0, 1'b1, 1'b0);   // no all-sync scan
        send_frame(0, 3, 1'b0, 1'b0, 1'b0);    // R9 dropped after scan 31 left
        repeat (4) @(posedge clk);
        chk(q.size() == 0, "R3", "pending items", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule